// File: doc/BRIEF.md
# TDM Audio Slot Deserializer

This block receives one direction of a single-wire time-division audio link and turns the serial bit stream into a frame of fixed-width slot words. The link carries a bit clock and a frame sync. The transmitter changes the data and the frame sync on rising bit-clock edges, and this block samples both on falling edges. The receive capture points therefore line up in time with the capture points of the outgoing direction. The block runs on a faster system clock. It brings the bit clock, the frame sync and the data line through one synchronizer, finds the falling bit-clock edges, and acts only on the values sampled at those edges.

A frame sync rising edge arms the receiver. The next falling edge captures the most significant bit of slot 0, and the remaining bits follow MSB first, slot after slot. Once bit 0 of the last slot is in, all slot words are copied to the output registers at the same moment, and a one-cycle done strobe pulses. A sample view gives the upper sample-width bits of each slot. If a frame sync arrives before the frame is complete, the partial frame is dropped, a sticky error flag is raised, and reception starts again at slot 0. Bits that arrive after a complete frame with no new sync are ignored.

Top module: `tdm_slot_deser`

## Requirements
- R1: After reset, every slot word and sample output is zero, and the done strobe and the error flag are low.
- R2: A frame sync is recognised only as a change from 0 to 1 between two successive falling-edge samples of the sync line. A sync held high across several bit periods starts only one frame.
- R3: The first bit sampled on the falling edge after the one that saw the sync is bit 31 of slot 0. Bits arrive MSB first, and slot i lands in slot_words_o[i*32+31 : i*32].
- R4: samples_o[i*24+23 : i*24] equals bits 31..8 of slot i. Bits 7..0 of a slot have no effect on it.
- R5: When 8 x 32 bits have been captured, all slot words update in the same clock cycle, and frame_done_o is high for exactly one clock cycle in that cycle. Outputs do not change at any other time.
- R6: A sync seen after one or more bits of a frame but before the last one discards the partial frame, so the outputs stay unchanged and no done pulse occurs. It sets frame_err_o and restarts reception at slot 0 with the next falling edge.
- R7: After a complete frame, data bits are ignored until the next sync, so no done pulse occurs and the outputs stay unchanged.
- R8: A sync sampled on the same falling edge that captures bit 0 of slot 7 completes that frame without an error and arms the next one, so frames can run back to back.
- R9: frame_err_o stays high until the next frame completes, and it is low in the cycle in which frame_done_o is high.
- R10: Changes of the data or sync lines that are undone before the next falling bit-clock edge have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Link bit clock |
| fsync_i | input | 1 | Frame sync, launched on rising bit-clock edges |
| sdata_i | input | 1 | Serial audio data, launched on rising bit-clock edges |
| slot_words_o | output | 256 | Eight 32-bit slot words, slot i at bits i*32+31..i*32 |
| samples_o | output | 192 | Eight 24-bit sample fields, slot i at bits i*24+23..i*24 |
| frame_done_o | output | 1 | One-cycle strobe when a full frame has been captured |
| frame_err_o | output | 1 | Sticky flag for a frame cut short by an early sync |

## Verification
The bench sends frames built from arithmetic patterns, including all zeros and all ones, and compares every slot word and sample field with the words it computes itself. A design that captured the bit on the sync-detect edge would shift each slot by one position. A design that retriggered on a sync level held high would restart partway into the frame. A design that failed to drop a short frame would publish mixed data or a spurious done pulse. Back-to-back frames, with the sync on the last bit, catch a design that raises a false error or loses the final bit. Stray bits after a finished frame catch a design that keeps counting. Data and sync glitches that are undone before the falling edge catch a design that samples on the wrong edge.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_RECV = 1'b1
  } rx_state_e;

  function automatic int frame_len(input int slots, input int bits);
    return slots * bits;
  endfunction

endpackage

// File: rtl/tdm_rx_edge.sv
module tdm_rx_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fsync,
  input  logic sdata,
  output logic fall_evt,
  output logic fs_smp,
  output logic sd_smp
);

  localparam int LINES = 3;

  logic [LINES-1:0] sync_q [STAGES];
  logic             bclk_last;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[g] <= '0;
          else        sync_q[g] <= {sdata, fsync, bclk};
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[g] <= '0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_last <= 1'b0;
    else        bclk_last <= sync_q[STAGES-1][0];
  end

  assign fall_evt = bclk_last & ~sync_q[STAGES-1][0];
  assign fs_smp   = sync_q[STAGES-1][1];
  assign sd_smp   = sync_q[STAGES-1][2];

  // R10: a falling edge needs the bit clock to rise again before the next one
  p_fall_isolated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);

endmodule

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
  import tdm_rx_pkg::*;
#(
  parameter int FRAME_BITS = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fall_evt,
  input  logic                  fs_smp,
  input  logic                  sd_smp,
  output logic [FRAME_BITS-1:0] frame_bits,
  output logic                  frame_complete,
  output logic                  frame_err
);

  localparam int CW = $clog2(FRAME_BITS + 1);

  rx_state_e             state_q;
  logic [CW-1:0]         cnt_q;
  logic [CW-1:0]         cnt_after;
  logic [FRAME_BITS-1:0] shreg_q;
  logic                  fs_prev_q;
  logic                  fs_rise;
  logic                  capture;
  logic                  early_sync;

  assign fs_rise        = fall_evt & fs_smp & ~fs_prev_q;
  assign capture        = fall_evt & (state_q == S_RECV);
  assign cnt_after      = CW'(cnt_q + 1'b1);
  assign frame_complete = capture & (cnt_after == CW'(FRAME_BITS));
  assign early_sync     = fs_rise & (state_q == S_RECV) & ~frame_complete;
  assign frame_bits     = {shreg_q[FRAME_BITS-2:0], sd_smp};

  always_ff @(posedge clk) begin
    if (!rst_n)        fs_prev_q <= 1'b0;
    else if (fall_evt) fs_prev_q <= fs_smp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else if (fs_rise) begin
      state_q <= S_RECV;
      cnt_q   <= '0;
    end else if (frame_complete) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else if (capture) begin
      cnt_q   <= cnt_after;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       shreg_q <= '0;
    else if (capture) shreg_q <= frame_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              frame_err <= 1'b0;
    else if (early_sync)     frame_err <= 1'b1;
    else if (frame_complete) frame_err <= 1'b0;
  end

  p_sync_only_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fs_rise |-> fall_evt);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(FRAME_BITS));

  p_restart_on_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    early_sync |=> (frame_err && state_q == S_RECV && cnt_q == '0));

  p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !fs_rise) |=> state_q == S_IDLE);

  p_idle_no_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |=> $stable(shreg_q));

  p_complete_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_complete |=> !frame_err);

endmodule

// File: rtl/tdm_rx_slot_bank.sv
module tdm_rx_slot_bank #(
  parameter int NUM_SLOTS   = 8,
  parameter int SLOT_BITS   = 32,
  parameter int SAMPLE_BITS = 24
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load,
  input  logic [NUM_SLOTS*SLOT_BITS-1:0]   frame_bits,
  output logic [NUM_SLOTS*SLOT_BITS-1:0]   slot_words,
  output logic [NUM_SLOTS*SAMPLE_BITS-1:0] samples,
  output logic                             done
);

  localparam int FB = NUM_SLOTS * SLOT_BITS;

  function automatic logic [SAMPLE_BITS-1:0] sample_of(input logic [SLOT_BITS-1:0] w);
    return w[SLOT_BITS-1 -: SAMPLE_BITS];
  endfunction

  generate
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n)    slot_words[i*SLOT_BITS +: SLOT_BITS] <= '0;
        else if (load) slot_words[i*SLOT_BITS +: SLOT_BITS] <= frame_bits[FB-1-i*SLOT_BITS -: SLOT_BITS];
      end
      assign samples[i*SAMPLE_BITS +: SAMPLE_BITS] = sample_of(slot_words[i*SLOT_BITS +: SLOT_BITS]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= load;
  end

  p_done_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> done);

  p_words_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(slot_words));

endmodule

// File: rtl/tdm_slot_deser.sv
module tdm_slot_deser #(
  parameter int NUM_SLOTS   = 8,
  parameter int SLOT_BITS   = 32,
  parameter int SAMPLE_BITS = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bclk_i,
  input  logic                             fsync_i,
  input  logic                             sdata_i,
  output logic [NUM_SLOTS*SLOT_BITS-1:0]   slot_words_o,
  output logic [NUM_SLOTS*SAMPLE_BITS-1:0] samples_o,
  output logic                             frame_done_o,
  output logic                             frame_err_o
);

  localparam int FRAME_BITS = tdm_rx_pkg::frame_len(NUM_SLOTS, SLOT_BITS);

  logic                  fall_evt;
  logic                  fs_smp;
  logic                  sd_smp;
  logic [FRAME_BITS-1:0] frame_bits;
  logic                  frame_complete;

  tdm_rx_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk     (bclk_i),
    .fsync    (fsync_i),
    .sdata    (sdata_i),
    .fall_evt (fall_evt),
    .fs_smp   (fs_smp),
    .sd_smp   (sd_smp)
  );

  tdm_rx_framer #(.FRAME_BITS(FRAME_BITS)) u_framer (
    .clk            (clk),
    .rst_n          (rst_n),
    .fall_evt       (fall_evt),
    .fs_smp         (fs_smp),
    .sd_smp         (sd_smp),
    .frame_bits     (frame_bits),
    .frame_complete (frame_complete),
    .frame_err      (frame_err_o)
  );

  tdm_rx_slot_bank #(
    .NUM_SLOTS   (NUM_SLOTS),
    .SLOT_BITS   (SLOT_BITS),
    .SAMPLE_BITS (SAMPLE_BITS)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (frame_complete),
    .frame_bits (frame_bits),
    .slot_words (slot_words_o),
    .samples    (samples_o),
    .done       (frame_done_o)
  );

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);

  p_done_clears_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> !frame_err_o);

endmodule

// File: tb/tdm_slot_deser_tb.sv
module tdm_slot_deser_tb;

  localparam int NS = 8;
  localparam int SB = 32;
  localparam int PB = 24;
  localparam int FB = NS * SB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0;
  logic fsync = 1'b0;
  logic sdata = 1'b0;
  logic [FB-1:0]    words;
  logic [NS*PB-1:0] samples;
  logic done;
  logic err;

  int compared = 0;
  int mismatched = 0;
  int done_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tdm_slot_deser u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bclk_i       (bclk),
    .fsync_i      (fsync),
    .sdata_i      (sdata),
    .slot_words_o (words),
    .samples_o    (samples),
    .frame_done_o (done),
    .frame_err_o  (err)
  );

  always @(posedge clk) if (rst_n && done) done_cnt <= done_cnt + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FB-1:0] make_frame(input int seed);
    logic [FB-1:0] f;
    for (int i = 0; i < NS; i++) begin
      logic [SB-1:0] w;
      if (seed == 0)      w = '0;
      else if (seed == 1) w = '1;
      else w = (32'(seed) * 32'h9E3779B1) ^ (32'(i) * 32'h01234567) ^ 32'(i + 1);
      f[FB-1-i*SB -: SB] = w;
    end
    return f;
  endfunction

  // one bit period: launch on rising bclk, hold across falling
  task automatic drive(input logic fs, input logic d, input bit glitch);
    @(negedge clk);
    bclk = 1'b1; fsync = fs; sdata = d;
    if (glitch) begin
      @(negedge clk); sdata = ~d; fsync = 1'b1;
      @(negedge clk); sdata = d;  fsync = fs;
      repeat (2) @(negedge clk);
    end else begin
      repeat (4) @(negedge clk);
    end
    bclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [FB-1:0] f, input int first, input int count,
                      input bit start_sync, input bit end_sync, input bit glitch);
    if (start_sync) drive(1'b1, 1'b0, 1'b0);
    for (int k = first; k < first + count; k++)
      drive((end_sync && k == first + count - 1) ? 1'b1 : 1'b0, f[FB-1-k], glitch);
  endtask

  task automatic idle_bits(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 1'b0);
  endtask

  task automatic check_frame(input logic [FB-1:0] f, input string ctx);
    for (int i = 0; i < NS; i++) begin
      logic [SB-1:0] w;
      w = f[FB-1-i*SB -: SB];
      chk({"R3 slot word ", ctx}, 64'(words[i*SB +: SB]), 64'(w));
      chk({"R4 sample ", ctx}, 64'(samples[i*PB +: PB]), 64'(w[SB-1:8]));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    logic [FB-1:0] fa, fb, fc, fd, fe, ff, fg, fh;
    int d0;
    fa = make_frame(5);  fb = make_frame(6);  fc = make_frame(7);
    fd = make_frame(0);  fe = make_frame(1);  ff = make_frame(9);
    fg = make_frame(11); fh = make_frame(12);

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 words", 64'(words == '0), 64'd1);
    chk("R1 samples", 64'(samples == '0), 64'd1);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 err", 64'(err), 64'd0);

    // R7 bits before any sync are ignored
    idle_bits(20);
    chk("R7 no done before sync", 64'(done_cnt), 64'd0);

    // R3 R4 R5 normal frame
    send(fa, 0, FB, 1'b1, 1'b0, 1'b0);
    idle_bits(2);
    check_frame(fa, "frame A");
    chk("R5 one done per frame", 64'(done_cnt), 64'd1);
    chk("R9 err low", 64'(err), 64'd0);

    // R7 stray bits after complete frame
    for (int k = 0; k < 40; k++) drive(1'b0, 1'b1, 1'b0);
    chk("R7 no extra done", 64'(done_cnt), 64'd1);
    check_frame(fa, "R7 after stray");

    // R2 sync held high over the first data bits
    drive(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < FB; k++) drive(k < 3 ? 1'b1 : 1'b0, fb[FB-1-k], 1'b0);
    idle_bits(2);
    check_frame(fb, "R2 held sync");
    chk("R2 single frame", 64'(done_cnt), 64'd2);

    // R6 early sync after 100 bits
    d0 = done_cnt;
    send(fc, 0, 100, 1'b1, 1'b0, 1'b0);
    send(fd, 0, 10, 1'b1, 1'b0, 1'b0);
    chk("R6 err set", 64'(err), 64'd1);
    chk("R6 no done on partial", 64'(done_cnt), 64'(d0));
    check_frame(fb, "R6 outputs kept");
    send(fd, 10, FB - 10, 1'b0, 1'b1, 1'b0);
    // R8 back-to-back: sync rode on the last bit of D
    send(fe, 0, 1, 1'b0, 1'b0, 1'b0);
    check_frame(fd, "R6 restart frame D");
    chk("R9 err cleared", 64'(err), 64'd0);
    send(fe, 1, FB - 1, 1'b0, 1'b0, 1'b0);
    idle_bits(2);
    check_frame(fe, "R8 back-to-back E");
    chk("R8 no error", 64'(err), 64'd0);
    chk("R8 two dones", 64'(done_cnt), 64'(d0 + 2));

    // R10 glitches undone before the falling edge
    send(ff, 0, FB, 1'b1, 1'b0, 1'b1);
    idle_bits(2);
    check_frame(ff, "R10 glitch");
    chk("R10 err untouched", 64'(err), 64'd0);

    // R6 sync on the second data bit
    d0 = done_cnt;
    send(fg, 0, 1, 1'b1, 1'b0, 1'b0);
    send(fh, 0, 10, 1'b1, 1'b0, 1'b0);
    chk("R6 early err", 64'(err), 64'd1);
    chk("R9 err sticky", 64'(err), 64'd1);
    check_frame(ff, "R6 outputs kept 2");
    send(fh, 10, FB - 10, 1'b0, 1'b0, 1'b0);
    idle_bits(2);
    check_frame(fh, "R6 restart H");
    chk("R9 err clear after H", 64'(err), 64'd0);
    chk("R5 done count", 64'(done_cnt), 64'(d0 + 1));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule